// File: doc/BRIEF.md
# Triggered One-Pulse Generator

This block emits one delayed pulse each time an armed trigger input shows its selected edge. While idle, the counter rests at zero and the pulse pin holds its passive level. A qualifying edge, after passing a two-flop synchronizer, starts the counter. The pin stays passive until the count equals the compare value. It is then active until the count has passed the reload value. At that point the counter halts by itself and raises a sticky done flag.

The compare value sets the delay from trigger to pulse. The span from compare to reload sets the pulse width. Both values are captured when the counter starts, so the pulse being generated is fixed even if they change later. Further trigger edges are ignored while a pulse is in progress. Software acknowledges completion through a one-cycle clear strobe.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: While reset is high and on the first clock after it, `pulse_o` equals `out_pol_i` (the passive level) and `done_o` is 0.
- R2: With `trig_pol_i` = 0 only a 0-to-1 change of `trig_i` starts the counter; with `trig_pol_i` = 1 only a 1-to-0 change does; a change in the other direction starts nothing.
- R3: If the new trigger level is first sampled at clock edge k, the counter holds 0 after edge k+2 and then advances by one per clock.
- R4: With count value j after edge k+2+j, the pin is active exactly for ccr <= j <= arr, so the pulse lasts arr-ccr+1 clocks; if ccr > arr no pulse appears.
- R5: At the edge after the count reached arr, the counter stops at 0, the pin returns to passive and `done_o` becomes 1 (edge k+3+arr).
- R6: Output polarity: `out_pol_i` = 0 makes the active level 1 and the passive level 0; `out_pol_i` = 1 inverts both.
- R7: Trigger edges that arrive while the counter runs have no effect on the running pulse and do not start a second one.
- R8: Compare and reload values are captured at the start; changing `cmp_i` or `reload_i` during a run does not alter that pulse.
- R9: `done_clr_i` high at a clock edge clears `done_o`; if the stop and the clear fall on the same edge, `done_o` ends up 1.
- R10: After stopping, the counter stays idle with the pin passive until a new qualifying edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Asynchronous trigger input |
| trig_pol_i | input | 1 | Trigger edge select: 0 rising, 1 falling |
| out_pol_i | input | 1 | Output polarity: 0 active-high, 1 active-low |
| cmp_i | input | CNT_W | Compare value (passive delay) |
| reload_i | input | CNT_W | Reload value (last count of the run) |
| done_clr_i | input | 1 | Clears the done flag |
| pulse_o | output | 1 | Registered pulse output |
| done_o | output | 1 | Sticky completion flag |

## Verification
The stop of a run sets the done flag, and a software clear can arrive on that same clock edge. The bench raises the clear in the cycle where the count sits at the reload value. It then expects the flag to read 1 afterwards, because the set wins. A second collision comes from a trigger edge that is reissued during a pulse. For this case the bench judges the whole waveform against the arithmetic timeline of the first trigger and requires the pin to stay quiet after the run.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/oneshot_trig_sync.sv
module oneshot_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic pol_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= trig_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  always_comb begin
    if (pol_i) edge_o = prev_q & ~sync_q[LAST];
    else       edge_o = ~prev_q & sync_q[LAST];
  end

  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/oneshot_core.sv
module oneshot_core
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             done_clr_i,
  output logic             running_o,
  output logic             act_nxt_o,
  output logic             done_o
);
  run_state_e       run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] rl_q, rl_d;
  logic             done_q, done_d;
  logic             last_tick;

  assign last_tick = (run_q == ST_RUN) && (cnt_q == rl_q);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cmp_d  = cmp_q;
    rl_d   = rl_q;
    done_d = done_q & ~done_clr_i;
    if (run_q == ST_IDLE) begin
      if (start_i) begin
        run_d = ST_RUN;
        cnt_d = '0;
        cmp_d = cmp_i;
        rl_d  = reload_i;
      end
    end else if (last_tick) begin
      run_d  = ST_IDLE;
      cnt_d  = '0;
      done_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= ST_IDLE;
      cnt_q  <= '0;
      cmp_q  <= '0;
      rl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      rl_q   <= rl_d;
      done_q <= done_d;
    end
  end

  assign running_o = (run_q == ST_RUN);
  assign act_nxt_o = (run_d == ST_RUN) && (cnt_d >= cmp_d);
  assign done_o    = done_q;

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q == ST_RUN) |-> (cnt_q <= rl_q));

  // R7
  retrig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ((run_q == ST_RUN) && start_i && !last_tick) |=>
      ((run_q == ST_RUN) && (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((run_q == ST_RUN) && !last_tick) |=> ($stable(rl_q) && $stable(cmp_q)));

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    last_tick |=> (done_q && (run_q == ST_IDLE)));

  // R9
  done_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (done_clr_i && !last_tick) |=> !done_q);
endmodule

// File: rtl/oneshot_out_stage.sv
module oneshot_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic pol_i,
  output logic pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) pulse_o <= pol_i;
    else     pulse_o <= act_i ^ pol_i;
  end
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             trig_pol_i,
  input  logic             out_pol_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             done_clr_i,
  output logic             pulse_o,
  output logic             done_o
);
  logic start_edge;
  logic running;
  logic act_nxt;

  oneshot_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .pol_i  (trig_pol_i),
    .edge_o (start_edge)
  );

  oneshot_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_edge),
    .cmp_i      (cmp_i),
    .reload_i   (reload_i),
    .done_clr_i (done_clr_i),
    .running_o  (running),
    .act_nxt_o  (act_nxt),
    .done_o     (done_o)
  );

  oneshot_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act_nxt),
    .pol_i   (out_pol_i),
    .pulse_o (pulse_o)
  );

  // R6 R10
  passive_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(out_pol_i) && (pulse_o != out_pol_i)) |-> running);
endmodule

// File: tb/oneshot_pulse_gen_test.sv
`timescale 1ns/1ps
module oneshot_pulse_gen_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig = 1'b0;
  logic         tpol = 1'b0;
  logic         opol = 1'b0;
  logic [W-1:0] cmp = '0;
  logic [W-1:0] rld = '0;
  logic         clr = 1'b0;
  logic         pulse;
  logic         done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  oneshot_pulse_gen #(.CNT_W(W), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig),
    .trig_pol_i (tpol),
    .out_pol_i  (opol),
    .cmp_i      (cmp),
    .reload_i   (rld),
    .done_clr_i (clr),
    .pulse_o    (pulse),
    .done_o     (done)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  // mode 0 plain, 1 retrigger during run, 2 config change during run, 3 clear on stop edge
  task automatic run_pulse(input int c, input int a, input logic tp, input logic op, input int mode);
    @(negedge clk);
    tpol = tp; opol = op; trig = tp;
    cmp = W'(c); rld = W'(a);
    repeat (4) @(negedge clk);
    chk("R10 idle pin", pulse, op);
    chk("R10 idle done", done, 1'b0);
    trig = ~tp;
    repeat (3) @(negedge clk);
    for (int j = 0; j <= a + 1; j++) begin
      logic act;
      act = (j >= c) && (j <= a);
      chk("R4 R6 pulse level", pulse, act ^ op);
      if (j == a + 1) chk("R5 R9 done at stop", done, 1'b1);
      else            chk("R5 done during run", done, 1'b0);
      if (mode == 3 && j == a + 1) clr = 1'b0;
      if (mode == 1 && j == 0) trig = tp;
      if (mode == 1 && j == 2) trig = ~tp;
      if (mode == 2 && j == 1) begin cmp = W'(0); rld = W'(2); end
      if (mode == 3 && j == a) clr = 1'b1;
      @(negedge clk);
    end
    for (int j = 0; j < 6; j++) begin
      chk("R7 R10 no restart pin", pulse, op);
      chk("R7 R10 done held", done, 1'b1);
      @(negedge clk);
    end
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9 clear", done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pin", pulse, 1'b0);
    chk("R1 reset done", done, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset pin", pulse, 1'b0);
    chk("R1 post-reset done", done, 1'b0);

    // R2: rising change under falling-edge select must not start
    tpol = 1'b1; trig = 1'b1; cmp = '0; rld = W'(3);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk("R2 wrong edge pin", pulse, 1'b0);
      chk("R2 wrong edge done", done, 1'b0);
    end
    tpol = 1'b0;

    // R2 R3 R4 R5 R6: sweep of small compare/reload pairs and both polarities
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 6; a++)
        for (int c = 0; c < 6; c++)
          run_pulse(c, a, logic'(p[0]), logic'(p[1]), 0);

    // R7: edges reissued during a pulse
    run_pulse(2, 6, 1'b0, 1'b0, 1);
    run_pulse(1, 7, 1'b1, 1'b1, 1);
    // R8: configuration changed mid-run
    run_pulse(3, 6, 1'b0, 1'b0, 2);
    run_pulse(4, 8, 1'b1, 1'b1, 2);
    // R9: clear strobe on the stop edge
    run_pulse(1, 3, 1'b0, 1'b0, 3);
    run_pulse(0, 0, 1'b1, 1'b1, 3);
    // R4: wider values
    run_pulse(250, 300, 1'b0, 1'b0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule